// File: doc/BRIEF.md
# Three-Level DMA Transfer Sequencer

This block is the per-channel progress engine of a DMA channel. Software programs a transfer as three nested sizes: the number of beats in a fragment, the number of fragments in a block, and the number of blocks in a transaction. It also programs a request mode and an interrupt selection, then arms the channel with a start strobe. Each pulse on the hardware request line grants one quantum of work. Depending on the request mode, that quantum is a single fragment, a whole block, or the complete transaction. While the quantum is being served, the sequencer raises a beat enable toward the bus master and counts the per-beat done strobes that come back.

As each level of the hierarchy completes, the block emits a one-cycle completion pulse for that level. These completions are also recorded in sticky status bits. A decode of the programmed interrupt selection picks which of those bits drive the interrupt line. If the programmed sizes are invalid, the start is refused and a configuration-error status bit is recorded instead. Address generation, descriptor fetching for chained configurations, and the bus master itself sit outside this block.

Top module: `dma_hier_seq`

## Requirements
- R1: After reset the beat enable, all completion pulses, all five status bits and the interrupt line are low.
- R2: A start while idle with a zero beat count, zero fragment count or zero block count is refused. It sets status bit 4 (configuration error), and a later request produces no beats.
- R3: In request mode 0 (fragment), one request raises the beat enable for exactly one fragment's worth of accepted beats. The channel then waits for the next request.
- R4: In request mode 1 (block), one request covers one full block (fragments x beats). The channel then waits for the next request.
- R5: In request modes 2 (transaction) and 3 (chained list), one request covers the whole remaining transaction. After the final block the channel is idle, and further requests produce no beats until a new start.
- R6: Completion pulses are nested. The fragment pulse fires for every fragment, one cycle after its final accepted beat. The block pulse fires together with the last fragment of a block. The transaction pulse fires together with the block pulse of the last block.
- R7: The list-done pulse fires together with the transaction pulse only in request mode 3.
- R8: The status bits are bit 0 fragment, bit 1 block, bit 2 transaction, bit 3 list, and bit 4 configuration error. Each bit is set by its event and holds until a clear write with a one in that bit position.
- R9: The interrupt line is the OR of the status bits enabled by the interrupt selection latched at start. The selections are: 0 none, 1 fragment, 2 block, 3 block or fragment, 4 transaction, 5 transaction or fragment, 6 transaction or block, 7 list, 8 configuration error, and 9 to 15 none.
- R10: When a clear write and a new event for the same status bit fall in the same cycle, the bit ends up set. Bits without a new event are cleared.
- R11: A request while beats are being served, a beat done strobe while the beat enable is low, and a start while the channel is not idle all have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_frag_len_i | input | LEN_W | Beats per fragment |
| cfg_frag_cnt_i | input | FCNT_W | Fragments per block |
| cfg_blk_cnt_i | input | BCNT_W | Blocks per transaction |
| cfg_req_mode_i | input | 2 | Work granted per request (0..3) |
| cfg_int_type_i | input | 4 | Interrupt selection (0..8) |
| start_i | input | 1 | Arm the channel with the configuration inputs |
| hw_req_i | input | 1 | Hardware request |
| beat_done_i | input | 1 | One beat accepted by the bus master |
| clr_we_i | input | 1 | Status clear write strobe |
| clr_mask_i | input | 5 | Write-one-to-clear mask for the status bits |
| beat_en_o | output | 1 | Beats may be issued |
| frag_done_o | output | 1 | Fragment completion pulse |
| blk_done_o | output | 1 | Block completion pulse |
| trans_done_o | output | 1 | Transaction completion pulse |
| list_done_o | output | 1 | Chained-list completion pulse |
| int_stat_o | output | 5 | Sticky status bits |
| irq_o | output | 1 | Interrupt line |

## Verification
Two things can land on the same status bit in the same cycle: a software clear write, and a completion event that sets the bit again. The bench provokes this by asserting the clear strobe with every mask bit set during the cycle that carries the final beat of a transaction. In that cycle the fragment, block and transaction events all land on their bits. Earlier list and configuration-error bits are already set when this happens. The run passes when the freshly completed bits read back as one and the older bits read back as zero.

// File: rtl/hseq_pkg.sv
package hseq_pkg;

    typedef enum logic [1:0] {
        RQ_FRAG  = 2'd0,
        RQ_BLK   = 2'd1,
        RQ_TRANS = 2'd2,
        RQ_LIST  = 2'd3
    } req_mode_e;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_WAIT = 2'd1,
        CH_RUN  = 2'd2
    } ch_state_e;

    localparam int EVT_W = 5;

    typedef struct packed {
        logic cfgerr;
        logic list;
        logic trans;
        logic blk;
        logic frag;
    } evt_t;

    function automatic evt_t irq_mask(input logic [3:0] sel);
        evt_t m;
        m = '0;
        case (sel)
            4'd1: m.frag = 1'b1;
            4'd2: m.blk = 1'b1;
            4'd3: begin m.blk = 1'b1; m.frag = 1'b1; end
            4'd4: m.trans = 1'b1;
            4'd5: begin m.trans = 1'b1; m.frag = 1'b1; end
            4'd6: begin m.trans = 1'b1; m.blk = 1'b1; end
            4'd7: m.list = 1'b1;
            4'd8: m.cfgerr = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/hseq_cfg_check.sv
module hseq_cfg_check
    import hseq_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter int FCNT_W = 6,
    parameter int BCNT_W = 6
) (
    input  logic [LEN_W-1:0]  len_i,
    input  logic [FCNT_W-1:0] fcnt_i,
    input  logic [BCNT_W-1:0] bcnt_i,
    input  logic [3:0]        sel_i,
    output logic              cfg_ok_o,
    output evt_t              mask_o
);
    always_comb begin
        cfg_ok_o = (len_i != '0) && (fcnt_i != '0) && (bcnt_i != '0);
        mask_o   = irq_mask(sel_i);
    end
endmodule

// File: rtl/hseq_level_ctr.sv
module hseq_level_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         step_i,
    input  logic [W-1:0] limit_i,
    output logic         last_o
);
    logic [W-1:0] cnt_q;

    assign last_o = (cnt_q == limit_i - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= last_o ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/hseq_irq_status.sv
module hseq_irq_status
    import hseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  evt_t             set_i,
    input  logic             clr_we_i,
    input  logic [EVT_W-1:0] clr_mask_i,
    input  evt_t             mask_i,
    output logic [EVT_W-1:0] stat_o,
    output logic             irq_o
);
    logic [EVT_W-1:0] set_vec;
    logic [EVT_W-1:0] en_vec;

    assign set_vec = set_i;
    assign en_vec  = mask_i;

    for (genvar i = 0; i < EVT_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stat_o[i] <= 1'b0;
            end else if (set_vec[i]) begin
                stat_o[i] <= 1'b1;
            end else if (clr_we_i && clr_mask_i[i]) begin
                stat_o[i] <= 1'b0;
            end
        end
    end

    assign irq_o = |(stat_o & en_vec);
endmodule

// File: rtl/dma_hier_seq.sv
module dma_hier_seq
    import hseq_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter int FCNT_W = 6,
    parameter int BCNT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEN_W-1:0]  cfg_frag_len_i,
    input  logic [FCNT_W-1:0] cfg_frag_cnt_i,
    input  logic [BCNT_W-1:0] cfg_blk_cnt_i,
    input  logic [1:0]        cfg_req_mode_i,
    input  logic [3:0]        cfg_int_type_i,
    input  logic              start_i,
    input  logic              hw_req_i,
    input  logic              beat_done_i,
    input  logic              clr_we_i,
    input  logic [4:0]        clr_mask_i,
    output logic              beat_en_o,
    output logic              frag_done_o,
    output logic              blk_done_o,
    output logic              trans_done_o,
    output logic              list_done_o,
    output logic [4:0]        int_stat_o,
    output logic              irq_o
);
    ch_state_e         state_q, state_d;
    logic [LEN_W-1:0]  len_q;
    logic [FCNT_W-1:0] fcnt_q;
    logic [BCNT_W-1:0] bcnt_q;
    req_mode_e         mode_q;
    logic [3:0]        sel_q;

    logic cfg_ok;
    evt_t irq_en;
    evt_t unused_mask;
    logic unused_ok;
    evt_t evt_d;
    logic [3:0] pulse_q;

    logic start_take, start_ok, beat_step, quantum_end;
    logic beat_last, frag_last, blk_last;

    // validation of the live inputs at start
    hseq_cfg_check #(.LEN_W(LEN_W), .FCNT_W(FCNT_W), .BCNT_W(BCNT_W)) u_chk_in (
        .len_i   (cfg_frag_len_i),
        .fcnt_i  (cfg_frag_cnt_i),
        .bcnt_i  (cfg_blk_cnt_i),
        .sel_i   (cfg_int_type_i),
        .cfg_ok_o(cfg_ok),
        .mask_o  (unused_mask)
    );

    // interrupt enable decode of the latched selection
    hseq_cfg_check #(.LEN_W(LEN_W), .FCNT_W(FCNT_W), .BCNT_W(BCNT_W)) u_chk_q (
        .len_i   (len_q),
        .fcnt_i  (fcnt_q),
        .bcnt_i  (bcnt_q),
        .sel_i   (sel_q),
        .cfg_ok_o(unused_ok),
        .mask_o  (irq_en)
    );

    assign start_take = start_i && (state_q == CH_IDLE);
    assign start_ok   = start_take && cfg_ok;
    assign beat_step  = (state_q == CH_RUN) && beat_done_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            fcnt_q <= '0;
            bcnt_q <= '0;
            mode_q <= RQ_FRAG;
            sel_q  <= '0;
        end else if (start_take) begin
            sel_q <= cfg_int_type_i;
            if (cfg_ok) begin
                len_q  <= cfg_frag_len_i;
                fcnt_q <= cfg_frag_cnt_i;
                bcnt_q <= cfg_blk_cnt_i;
                mode_q <= req_mode_e'(cfg_req_mode_i);
            end
        end
    end

    hseq_level_ctr #(.W(LEN_W)) u_beat_ctr (
        .clk(clk), .rst(rst), .clr_i(start_ok),
        .step_i(beat_step), .limit_i(len_q), .last_o(beat_last)
    );

    hseq_level_ctr #(.W(FCNT_W)) u_frag_ctr (
        .clk(clk), .rst(rst), .clr_i(start_ok),
        .step_i(evt_d.frag), .limit_i(fcnt_q), .last_o(frag_last)
    );

    hseq_level_ctr #(.W(BCNT_W)) u_blk_ctr (
        .clk(clk), .rst(rst), .clr_i(start_ok),
        .step_i(evt_d.blk), .limit_i(bcnt_q), .last_o(blk_last)
    );

    always_comb begin
        evt_d.frag   = beat_step && beat_last;
        evt_d.blk    = evt_d.frag && frag_last;
        evt_d.trans  = evt_d.blk && blk_last;
        evt_d.list   = evt_d.trans && (mode_q == RQ_LIST);
        evt_d.cfgerr = start_take && !cfg_ok;
        quantum_end  = evt_d.frag && ((mode_q == RQ_FRAG) ||
                       ((mode_q == RQ_BLK) && evt_d.blk) || evt_d.trans);
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            CH_IDLE: if (start_ok) state_d = CH_WAIT;
            CH_WAIT: if (hw_req_i) state_d = CH_RUN;
            CH_RUN: begin
                if (evt_d.trans)      state_d = CH_IDLE;
                else if (quantum_end) state_d = CH_WAIT;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_IDLE;
            pulse_q <= '0;
        end else begin
            state_q <= state_d;
            pulse_q <= {evt_d.list, evt_d.trans, evt_d.blk, evt_d.frag};
        end
    end

    hseq_irq_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .set_i     (evt_d),
        .clr_we_i  (clr_we_i),
        .clr_mask_i(clr_mask_i),
        .mask_i    (irq_en),
        .stat_o    (int_stat_o),
        .irq_o     (irq_o)
    );

    assign beat_en_o    = (state_q == CH_RUN);
    assign frag_done_o  = pulse_q[0];
    assign blk_done_o   = pulse_q[1];
    assign trans_done_o = pulse_q[2];
    assign list_done_o  = pulse_q[3];

    logic unused_sink;
    assign unused_sink = ^{unused_mask, unused_ok};
endmodule

// File: rtl/hseq_checker.sv
module hseq_checker (
    input logic       clk,
    input logic       rst,
    input logic       beat_done_i,
    input logic       clr_we_i,
    input logic [4:0] clr_mask_i,
    input logic       beat_en_o,
    input logic       frag_done_o,
    input logic       blk_done_o,
    input logic       trans_done_o,
    input logic       list_done_o,
    input logic [4:0] int_stat_o,
    input logic       irq_o
);
    logic [4:0] clr_vec;
    assign clr_vec = clr_we_i ? clr_mask_i : 5'd0;

    p_blk_nested_r6: assert property (@(posedge clk) disable iff (rst)
        blk_done_o |-> frag_done_o);

    p_trans_nested_r6: assert property (@(posedge clk) disable iff (rst)
        trans_done_o |-> blk_done_o);

    p_frag_after_beat_r6: assert property (@(posedge clk) disable iff (rst)
        frag_done_o |-> $past(beat_en_o && beat_done_i));

    p_list_with_trans_r7: assert property (@(posedge clk) disable iff (rst)
        list_done_o |-> trans_done_o);

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(int_stat_o) & ~$past(clr_vec) & ~int_stat_o) == 5'd0));

    p_irq_needs_status_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (int_stat_o != 5'd0));

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        frag_done_o |-> int_stat_o[0]);

    p_idle_beat_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (!beat_en_o && beat_done_i) |=> !frag_done_o);
endmodule

bind dma_hier_seq hseq_checker u_hseq_checker (
    .clk         (clk),
    .rst         (rst),
    .beat_done_i (beat_done_i),
    .clr_we_i    (clr_we_i),
    .clr_mask_i  (clr_mask_i),
    .beat_en_o   (beat_en_o),
    .frag_done_o (frag_done_o),
    .blk_done_o  (blk_done_o),
    .trans_done_o(trans_done_o),
    .list_done_o (list_done_o),
    .int_stat_o  (int_stat_o),
    .irq_o       (irq_o)
);

// File: tb/test_dma_hier_seq.sv
module test_dma_hier_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] len = '0;
    logic [5:0] fcnt = '0;
    logic [5:0] bcnt = '0;
    logic [1:0] rmode = '0;
    logic [3:0] itype = '0;
    logic       start = 1'b0;
    logic       hw_req = 1'b0;
    logic       beat_done = 1'b1;
    logic       clr_we = 1'b0;
    logic [4:0] clr_mask = '0;
    logic       beat_en, frag_d, blk_d, trans_d, list_d, irq;
    logic [4:0] stat;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [3:0] exp_q[$];
    int mf = 0, mb = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_hier_seq i_dma_hier_seq (
        .clk(clk), .rst(rst),
        .cfg_frag_len_i(len), .cfg_frag_cnt_i(fcnt), .cfg_blk_cnt_i(bcnt),
        .cfg_req_mode_i(rmode), .cfg_int_type_i(itype),
        .start_i(start), .hw_req_i(hw_req), .beat_done_i(beat_done),
        .clr_we_i(clr_we), .clr_mask_i(clr_mask),
        .beat_en_o(beat_en), .frag_done_o(frag_d), .blk_done_o(blk_d),
        .trans_done_o(trans_d), .list_done_o(list_d),
        .int_stat_o(stat), .irq_o(irq)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops expected pulse vectors {list,trans,blk,frag} (R6, R7)
    always @(negedge clk) begin
        if (!rst && (frag_d || blk_d || trans_d || list_d)) begin
            if (exp_q.size() == 0) begin
                check_eq("R6 unexpected pulse", int'({list_d, trans_d, blk_d, frag_d}), 0);
            end else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                check_eq("R6/R7 pulse vector", int'({list_d, trans_d, blk_d, frag_d}), int'(e));
            end
        end
    end

    // driver side of the scoreboard: model one quantum, return fragment count
    task automatic push_quantum(output int nfrag);
        bit stop;
        stop = 0;
        nfrag = 0;
        while (!stop) begin
            logic [3:0] v;
            v[0] = 1'b1;
            v[1] = (mf == int'(fcnt) - 1);
            v[2] = v[1] && (mb == int'(bcnt) - 1);
            v[3] = v[2] && (rmode == 2'd3);
            exp_q.push_back(v);
            nfrag++;
            if (v[1]) begin
                mf = 0;
                if (v[2]) mb = 0; else mb++;
            end else begin
                mf++;
            end
            stop = (rmode == 2'd0) || (rmode == 2'd1 && v[1]) || v[2];
        end
    endtask

    task automatic do_start(input int l, input int f, input int b, input int m, input int t);
        len = 8'(l); fcnt = 6'(f); bcnt = 6'(b); rmode = 2'(m); itype = 4'(t);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mf = 0; mb = 0;
        @(negedge clk);
    endtask

    task automatic do_clear(input logic [4:0] m);
        clr_we = 1'b1; clr_mask = m;
        @(negedge clk);
        clr_we = 1'b0; clr_mask = '0;
    endtask

    // issue one request and count beats; optional mid-run request and clear on last beat
    task automatic do_req(input string tag, input int exp_beats, input bit req_mid,
                          input bit clr_last);
        int n;
        hw_req = 1'b1;
        @(negedge clk);
        hw_req = 1'b0;
        n = 0;
        while (beat_en && n < 1000) begin
            n++;
            hw_req = (req_mid && n == 2) ? 1'b1 : 1'b0;
            if (clr_last && n == exp_beats) begin
                clr_we = 1'b1; clr_mask = 5'h1F;
            end
            @(negedge clk);
            clr_we = 1'b0; clr_mask = '0;
        end
        hw_req = 1'b0;
        @(negedge clk);
        check_eq(tag, n, exp_beats);
        check_eq("R6 all expected pulses seen", exp_q.size(), 0);
    endtask

    task automatic run_quantum(input string tag, input bit req_mid, input bit clr_last);
        int nf;
        push_quantum(nf);
        do_req(tag, nf * int'(len), req_mid, clr_last);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 beat_en", int'(beat_en), 0);
        check_eq("R1 pulses", int'({list_d, trans_d, blk_d, frag_d}), 0);
        check_eq("R1 status", int'(stat), 0);
        check_eq("R1 irq", int'(irq), 0);

        // R2 refused start with zero beat count, selection 8 (cfg error)
        do_start(0, 2, 2, 0, 8);
        check_eq("R2 cfgerr bit4", int'(stat), 5'h10);
        check_eq("R9 irq sel 8", int'(irq), 1);
        do_req("R2 no beats after refused start", 0, 0, 0);
        do_start(3, 0, 2, 0, 8);
        check_eq("R2 zero frag count", int'(stat), 5'h10);
        do_clear(5'h10);
        check_eq("R8 clear cfgerr", int'(stat), 0);
        check_eq("R9 irq after clear", int'(irq), 0);

        // R3 fragment mode, 3 beats x 2 frags x 2 blocks, selection 1
        do_start(3, 2, 2, 0, 1);
        run_quantum("R3 fragment quantum 1", 0, 0);
        check_eq("R8 frag bit set", int'(stat), 5'h01);
        check_eq("R9 irq sel 1", int'(irq), 1);
        run_quantum("R3 fragment quantum 2", 0, 0);
        check_eq("R8 frag+blk bits", int'(stat), 5'h03);
        run_quantum("R3 fragment quantum 3", 0, 0);
        run_quantum("R3 fragment quantum 4", 0, 0);
        check_eq("R8 after transaction", int'(stat), 5'h07);
        do_req("R5 idle after transaction", 0, 0, 0);
        repeat (4) @(negedge clk);
        check_eq("R11 idle beat_done no effect", int'(stat), 5'h07);
        do_clear(5'h1F);

        // R4 block mode, selection 2, extra request mid-run ignored (R11)
        do_start(2, 3, 2, 1, 2);
        run_quantum("R4 block quantum with R11 mid request", 1, 0);
        check_eq("R9 irq sel 2", int'(irq), 1);
        check_eq("R11 waits after block", int'(beat_en), 0);
        run_quantum("R4 block quantum 2", 0, 0);
        check_eq("R8 block mode status", int'(stat), 5'h07);
        do_clear(5'h1F);

        // R5 transaction mode, selection 4; start while running ignored (R11)
        len = 8'd1; fcnt = 6'd2; bcnt = 6'd3; rmode = 2'd2; itype = 4'd4;
        start = 1'b1; @(negedge clk); start = 1'b0; mf = 0; mb = 0;
        @(negedge clk);
        begin
            int nf;
            push_quantum(nf);
            hw_req = 1'b1; @(negedge clk); hw_req = 1'b0;
            len = 8'd0; start = 1'b1; @(negedge clk); start = 1'b0; len = 8'd1;
            repeat (10) @(negedge clk);
            check_eq("R11 start while busy no cfgerr", int'(stat[4]), 0);
            check_eq("R5 transaction pulses seen", exp_q.size(), 0);
        end
        check_eq("R9 irq sel 4", int'(irq), 1);
        do_req("R5 idle after one request", 0, 0, 0);

        // R7 list mode, selection 7
        do_start(2, 1, 2, 3, 7);
        check_eq("R9 irq sel 7 before list", int'(irq), 0);
        run_quantum("R5 list quantum", 0, 0);
        check_eq("R7 list bit", int'(stat[3]), 1);
        check_eq("R9 irq sel 7", int'(irq), 1);

        // R10 clear in the same cycle as a completion; set cfgerr first
        do_start(0, 1, 1, 0, 8);
        check_eq("R2 cfgerr before R10", int'(stat), 5'h1F);
        do_start(2, 1, 1, 2, 4);
        run_quantum("R5 quantum for R10", 0, 1);
        check_eq("R10 set wins over clear", int'(stat), 5'h07);

        // R9 selection 6 ignores fragment-only status
        do_clear(5'h1F);
        do_start(1, 2, 1, 0, 6);
        run_quantum("R3 fragment for R9", 0, 0);
        check_eq("R9 sel 6 frag only irq low", int'(irq), 0);
        run_quantum("R3 fragment 2 for R9", 0, 0);
        check_eq("R9 sel 6 irq high", int'(irq), 1);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule